// File: doc/BRIEF.md
# Maskable Interrupt Controller Register Bank

This block gathers a set of level-sensitive, active-high interrupt sources and turns them into two processor request lines: a normal request (IRQ) and a fast request (FIQ). Software can steer each source to either line, enable or mask it, and raise it artificially for bring-up. It reads the state of every source through a small register file on a synchronous, word-addressed bus. Enable bits and software interrupt bits each have their own set and clear registers, so that one bit can change without a read-modify-write.

Nothing is latched. A source's pending state follows its input level and its software bit, so an interrupt ends when its cause is removed. The masked IRQ pending vector also goes out on its own port, for a neighbouring arbitration block. A protection bit can lock the register file against accesses made outside privileged mode.

Top module: `intc_regs`

## Requirements
- R1: After reset, the route, enable, software and protection registers read 0, and `irq_o` and `fiq_o` are 0.
- R2: The raw status register (word index 2, read-only) returns, for each source, the OR of the input pin and the software interrupt bit. No enable or route mask is applied.
- R3: The IRQ status register (word index 0) returns the bits that are raised, enabled and routed to IRQ. The FIQ status register (word index 1) returns the bits that are raised, enabled and routed to FIQ. Both follow the source levels with no latching.
- R4: The route register (word index 3) is read/write. A bit of 1 steers that source to FIQ, and a bit of 0 steers it to IRQ.
- R5: Writing to the enable register (word index 4) sets the enable bits where the data is 1, and the register reads back. Writing to word index 5 clears the enable bits where the data is 1. Data bits of 0 leave an enable bit unchanged in both registers.
- R6: Writing to word index 6 sets the software interrupt bits where the data is 1, and the register reads back. Writing to word index 7 clears the bits where the data is 1. Data bits of 0 have no effect.
- R7: Reads of the write-only indices 5 and 7, and of any unmapped index, return 0.
- R8: Bit 0 of word index 8 is the protection bit. While it is 1 and `priv_i` is 0, writes to any register are ignored and reads return 0. Privileged accesses are not affected.
- R9: `irq_o` is the OR of the IRQ status bits, and `fiq_o` is the OR of the FIQ status bits. Each output follows its status one clock edge later.
- R10: `irq_pend_o` presents the IRQ status vector combinationally, with the same value as a read of word index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source levels, active high |
| addr_i | input | AW | Register word index |
| wdata_i | input | NSRC | Write data |
| we_i | input | 1 | Write strobe, takes effect at the clock edge |
| priv_i | input | 1 | 1 when the access is made in privileged mode |
| rdata_o | output | NSRC | Read data, combinational from the address |
| irq_pend_o | output | NSRC | Masked IRQ pending vector |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A register write takes effect at the clock edge where the strobe is sampled. The bench drives each access half a cycle before that edge and reads back from the following falling edge, once the write has landed. Read data and `irq_pend_o` are combinational, so the bench samples them 1 ns after it changes the address or the source pins, within the same cycle. The request outputs carry one register stage. The bench therefore checks them twice: once in the cycle where their status changes, where they must still hold the old value, and again after the next rising edge, where they must hold the new one.

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int NSRC = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            we_i,
  input  logic            priv_i,
  output logic [NSRC-1:0] rdata_o,
  output logic [NSRC-1:0] irq_pend_o,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam logic [AW-1:0] A_IRQST  = AW'(0);
  localparam logic [AW-1:0] A_FIQST  = AW'(1);
  localparam logic [AW-1:0] A_RAW    = AW'(2);
  localparam logic [AW-1:0] A_ROUTE  = AW'(3);
  localparam logic [AW-1:0] A_ENSET  = AW'(4);
  localparam logic [AW-1:0] A_ENCLR  = AW'(5);
  localparam logic [AW-1:0] A_SWSET  = AW'(6);
  localparam logic [AW-1:0] A_SWCLR  = AW'(7);
  localparam logic [AW-1:0] A_LOCK   = AW'(8);

  logic [NSRC-1:0] route_q, en_q, sw_q;
  logic            lock_q;
  logic            allow, wr_ok;
  logic [NSRC-1:0] level, irq_st, fiq_st;

  assign allow  = !lock_q || priv_i;
  assign wr_ok  = we_i && allow;
  assign level  = src_i | sw_q;
  assign irq_st = level & en_q & ~route_q;
  assign fiq_st = level & en_q & route_q;
  assign irq_pend_o = irq_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      sw_q    <= '0;
      lock_q  <= 1'b0;
    end else if (wr_ok) begin
      case (addr_i)
        A_ROUTE: route_q <= wdata_i;
        A_ENSET: en_q    <= en_q | wdata_i;
        A_ENCLR: en_q    <= en_q & ~wdata_i;
        A_SWSET: sw_q    <= sw_q | wdata_i;
        A_SWCLR: sw_q    <= sw_q & ~wdata_i;
        A_LOCK:  lock_q  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_st;
      fiq_o <= |fiq_st;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (allow) begin
      case (addr_i)
        A_IRQST: rdata_o = irq_st;
        A_FIQST: rdata_o = fiq_st;
        A_RAW:   rdata_o = level;
        A_ROUTE: rdata_o = route_q;
        A_ENSET: rdata_o = en_q;
        A_SWSET: rdata_o = sw_q;
        A_LOCK:  rdata_o = {{(NSRC-1){1'b0}}, lock_q};
        default: rdata_o = '0;
      endcase
    end
  end

  // R9
  irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|((src_i | sw_q) & en_q & ~route_q)));

  // R9
  fiq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == $past(|((src_i | sw_q) & en_q & route_q)));

  // R8
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && lock_q && !priv_i) |=> ($stable(en_q) && $stable(route_q) && $stable(sw_q) && lock_q));

  // R5
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr_i == A_ENCLR) |=> ((en_q & $past(wdata_i)) == '0));

  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr_i == A_SWSET) |=> ((sw_q & $past(wdata_i)) == $past(wdata_i)));

  // R10
  pend_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && addr_i == A_IRQST) |-> (rdata_o == irq_pend_o));

endmodule

// File: tb/intc_regs_test.sv
module intc_regs_test;
  localparam int NSRC = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic [AW-1:0]   addr_i = '0;
  logic [NSRC-1:0] wdata_i = '0;
  logic            we_i = 1'b0;
  logic            priv_i = 1'b1;
  logic [NSRC-1:0] rdata_o, irq_pend_o;
  logic            irq_o, fiq_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  intc_regs #(.NSRC(NSRC), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .priv_i(priv_i),
    .rdata_o(rdata_o), .irq_pend_o(irq_pend_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [NSRC-1:0] got, input logic [NSRC-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [NSRC-1:0] d, input logic pv);
    addr_i = AW'(idx); wdata_i = d; priv_i = pv; we_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we_i = 1'b0; wdata_i = '0; priv_i = 1'b1;
  endtask

  task automatic rd(input int idx, input logic pv, output logic [NSRC-1:0] d);
    addr_i = AW'(idx); priv_i = pv;
    #1;
    d = rdata_o;
    priv_i = 1'b1;
  endtask

  task automatic clean();
    wr(5, '1, 1'b1);
    wr(7, '1, 1'b1);
    wr(3, '0, 1'b1);
    src_i = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NSRC-1:0] d;
    rd(3, 1'b1, d); check("R1 route", d, '0);
    rd(4, 1'b1, d); check("R1 enable", d, '0);
    rd(6, 1'b1, d); check("R1 soft", d, '0);
    rd(8, 1'b1, d); check("R1 lock", d, '0);
    check("R1 irq_o", {31'b0, irq_o}, '0);
    check("R1 fiq_o", {31'b0, fiq_o}, '0);
  endtask

  task automatic t_raw();
    logic [NSRC-1:0] d;
    src_i = 32'hC3A5_0F01;
    rd(2, 1'b1, d); check("R2 raw pins", d, 32'hC3A5_0F01);
    rd(0, 1'b1, d); check("R3 masked while disabled", d, '0);
    src_i = 32'h0000_8000;
    rd(2, 1'b1, d); check("R2 raw follows", d, 32'h0000_8000);
    src_i = '0;
  endtask

  task automatic t_enable();
    logic [NSRC-1:0] d;
    wr(4, 32'hA5A5_0000, 1'b1);
    rd(4, 1'b1, d); check("R5 set", d, 32'hA5A5_0000);
    wr(4, 32'h0000_000F, 1'b1);
    rd(4, 1'b1, d); check("R5 set accumulates", d, 32'hA5A5_000F);
    wr(5, 32'h0, 1'b1);
    rd(4, 1'b1, d); check("R5 clear zeros no effect", d, 32'hA5A5_000F);
    wr(5, 32'h8000_0005, 1'b1);
    rd(4, 1'b1, d); check("R5 clear ones", d, 32'h25A5_000A);
    clean();
  endtask

  task automatic t_route();
    logic [NSRC-1:0] d;
    wr(3, 32'hFF00_FF00, 1'b1);
    rd(3, 1'b1, d); check("R4 route readback", d, 32'hFF00_FF00);
    wr(4, 32'h0FFF_FFF0, 1'b1);
    src_i = 32'h1234_5678;
    rd(0, 1'b1, d); check("R3 irq status", d, 32'h1234_5678 & 32'h0FFF_FFF0 & 32'h00FF_00FF);
    rd(1, 1'b1, d); check("R3 fiq status", d, 32'h1234_5678 & 32'h0FFF_FFF0 & 32'hFF00_FF00);
    check("R10 pend port", irq_pend_o, 32'h1234_5678 & 32'h0FFF_FFF0 & 32'h00FF_00FF);
    src_i = 32'h0000_0010;
    rd(0, 1'b1, d); check("R3 no latch irq", d, 32'h0000_0010);
    rd(1, 1'b1, d); check("R3 no latch fiq", d, '0);
    check("R10 pend follows", irq_pend_o, 32'h0000_0010);
    clean();
  endtask

  task automatic t_soft();
    logic [NSRC-1:0] d;
    wr(6, 32'h0000_0300, 1'b1);
    rd(6, 1'b1, d); check("R6 soft set", d, 32'h0000_0300);
    rd(2, 1'b1, d); check("R2 raw with soft", d, 32'h0000_0300);
    src_i = 32'h0000_0001;
    rd(2, 1'b1, d); check("R2 raw pin or soft", d, 32'h0000_0301);
    wr(7, 32'h0, 1'b1);
    rd(6, 1'b1, d); check("R6 clear zeros no effect", d, 32'h0000_0300);
    wr(7, 32'h0000_0100, 1'b1);
    rd(6, 1'b1, d); check("R6 clear ones", d, 32'h0000_0200);
    clean();
  endtask

  task automatic t_wo();
    logic [NSRC-1:0] d;
    wr(4, '1, 1'b1);
    wr(6, 32'h0000_00F0, 1'b1);
    rd(5, 1'b1, d); check("R7 enable clear reads 0", d, '0);
    rd(7, 1'b1, d); check("R7 soft clear reads 0", d, '0);
    rd(9, 1'b1, d); check("R7 unmapped reads 0", d, '0);
    rd(63, 1'b1, d); check("R7 top index reads 0", d, '0);
    clean();
  endtask

  task automatic t_outputs();
    wr(4, 32'h0000_0001, 1'b1);
    src_i = 32'h0000_0001;
    #1;
    check("R9 irq_o not yet", {31'b0, irq_o}, '0);
    @(negedge clk);
    check("R9 irq_o one edge later", {31'b0, irq_o}, 32'h1);
    check("R9 fiq_o idle", {31'b0, fiq_o}, '0);
    wr(3, 32'h0000_0001, 1'b1);
    check("R9 irq_o still old", {31'b0, irq_o}, 32'h1);
    check("R9 fiq_o still old", {31'b0, fiq_o}, '0);
    @(negedge clk);
    check("R9 irq_o dropped", {31'b0, irq_o}, '0);
    check("R9 fiq_o raised", {31'b0, fiq_o}, 32'h1);
    src_i = '0;
    @(negedge clk);
    check("R9 fiq_o follows level", {31'b0, fiq_o}, '0);
    clean();
  endtask

  task automatic t_lock();
    logic [NSRC-1:0] d;
    wr(4, 32'h0000_00FF, 1'b0);
    rd(4, 1'b1, d); check("R8 user write when unlocked", d, 32'h0000_00FF);
    wr(8, 32'hFFFF_FFFF, 1'b1);
    rd(8, 1'b1, d); check("R8 lock bit only bit 0", d, 32'h1);
    wr(4, '1, 1'b0);
    wr(5, 32'h0000_000F, 1'b0);
    wr(6, 32'h0000_F000, 1'b0);
    rd(4, 1'b1, d); check("R8 user enable write ignored", d, 32'h0000_00FF);
    rd(6, 1'b1, d); check("R8 user soft write ignored", d, '0);
    rd(4, 1'b0, d); check("R8 user read blocked", d, '0);
    wr(8, 32'h0, 1'b0);
    rd(8, 1'b1, d); check("R8 user unlock ignored", d, 32'h1);
    wr(5, 32'h0000_000F, 1'b1);
    rd(4, 1'b1, d); check("R8 priv write allowed", d, 32'h0000_00F0);
    wr(8, 32'h0, 1'b1);
    rd(4, 1'b0, d); check("R8 user read after unlock", d, 32'h0000_00F0);
    clean();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_enable();
    t_route();
    t_soft();
    t_wo();
    t_outputs();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule